// File: doc/BRIEF.md
# Reset pin function selector

This block decides what a shared external pin does. The pin can be an active-low reset input or a plain digital input. A configuration fuse picks between the two, but the pin always acts as a reset while power-up is in progress. The block samples the fuse once, on the strobe that marks the end of the power-up delay. After that it keeps the chosen function until the next power-on reset. Watchdog, software and brown-out resets do not change it.

The block also produces the in-system-programming enable. When the pin works as a reset, holding it low enables programming. When the fuse selects digital input, programming can only be entered by holding the pin low through power-up. In that case the block latches the decision at the end of the delay and holds it until the next power-on reset. If the pin is low at that moment, the device stays in reset until the pin is released.

The raw pad level passes through a synchronizer before any of these decisions use it.

Top module: `rpin_sel`

## Requirements
- R1: From power-on release until the power-up-done strobe, the pin acts as a reset whatever the fuse says: `ext_rst_req_o` and `isp_en_o` are the inverse of the synchronized pin, and `gpio_data_o` reads 1.
- R2: If `fuse_rst_en_i` is 1 when the strobe arrives, the pin becomes a reset input. `ext_rst_req_o` is then the inverse of the synchronized pin, and `gpio_data_o` reads 1.
- R3: If `fuse_rst_en_i` is 0 and the synchronized pin is high when the strobe arrives, the pin becomes a digital input. `ext_rst_req_o` is then 0 and `gpio_data_o` follows the synchronized pin.
- R4: If `fuse_rst_en_i` is 0 and the synchronized pin is low when the strobe arrives, `ext_rst_req_o` stays 1 until the synchronized pin goes high. After that the pin works as a digital input.
- R5: In reset-pin mode, `isp_en_o` is 1 exactly while the synchronized pin is low.
- R6: In digital-input mode, `isp_en_o` equals the inverse of the synchronized pin as sampled at the strobe. It does not change when the pin changes later.
- R7: Once the strobe has been taken, further strobes and changes of `fuse_rst_en_i` have no effect until the next power-on reset.
- R8: Internal reset requests (`int_rst_req_i`, any bit) change neither the selected function nor the programming latch.
- R9: The pin passes through a two-stage synchronizer. After a change of `pin_raw_i`, `gpio_data_o` keeps its old value for one clock edge and shows the new value after the second edge.
- R10: Asserting `por_i` returns the block to its power-up behaviour and clears the programming latch. While `por_i` is high, `ext_rst_req_o`=0, `gpio_data_o`=1 and `isp_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, asynchronous, active high |
| pwrup_done_i | input | 1 | One-cycle strobe marking the end of the power-up delay |
| fuse_rst_en_i | input | 1 | Fuse: 1 selects reset function, 0 selects digital input |
| pin_raw_i | input | 1 | Raw level of the shared pin |
| int_rst_req_i | input | N_INT_RST | Internal reset requests (watchdog, software, brown-out) |
| ext_rst_req_o | output | 1 | Reset request coming from the pin |
| gpio_data_o | output | 1 | Synchronized pin data in digital-input mode, else 1 |
| isp_en_o | output | 1 | In-system-programming enable |

## Verification
The bench drives the pin low across the strobe with the fuse set to digital input. A design that released reset at once, or that failed to latch the programming enable, would show `ext_rst_req_o` low too early or `isp_en_o` dropping when the pin later rises. It also sends strobes again, flips the fuse, and pulses internal resets after power-up. A design that re-read the fuse would turn a digital pin back into a reset, or the reverse. Finally, it counts clock edges after a pin change and issues a second power-on reset. A wrong synchronizer depth would show up as an early or late edge, and a sticky latch would leave programming enabled after power-on.

// File: rtl/rpin_pkg.sv
package rpin_pkg;

    typedef enum logic [1:0] {
        PM_PWRUP  = 2'd0,
        PM_HOLD   = 2'd1,
        PM_RSTPIN = 2'd2,
        PM_GPIO   = 2'd3
    } pin_mode_e;

    typedef struct packed {
        pin_mode_e mode;
        logic      isp_lat;
    } mode_state_t;

    typedef struct packed {
        logic ext_rst;
        logic gpio;
        logic isp;
    } pin_out_t;

    localparam mode_state_t MODE_RST_VAL = '{mode: PM_PWRUP, isp_lat: 1'b0};
    localparam pin_out_t    OUT_RST_VAL  = '{ext_rst: 1'b0, gpio: 1'b1, isp: 1'b0};

endpackage

// File: rtl/rpin_sync.sv
module rpin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic din_i,
    output logic dout_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = din_i;
        for (int i = 1; i <= LAST; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) chain_q <= {STAGES{RST_VAL}};
        else       chain_q <= chain_d;
    end

    assign dout_o = chain_q[LAST];

    initial begin
        if (STAGES < 2) $error("rpin_sync needs at least two stages");
    end
endmodule

// File: rtl/rpin_mode_fsm.sv
module rpin_mode_fsm
    import rpin_pkg::*;
#(
    parameter int N_INT_RST = 3
) (
    input  logic                 clk_i,
    input  logic                 por_i,
    input  logic                 pwrup_done_i,
    input  logic                 fuse_rst_en_i,
    input  logic                 pin_s_i,
    input  logic [N_INT_RST-1:0] int_rst_req_i,
    output pin_mode_e            mode_o,
    output logic                 isp_lat_o
);
    mode_state_t st_d, st_q;
    logic        any_int_rst;

    assign any_int_rst = |int_rst_req_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            PM_PWRUP: begin
                if (pwrup_done_i) begin
                    if (fuse_rst_en_i) begin
                        st_d.mode = PM_RSTPIN;
                    end else begin
                        st_d.isp_lat = ~pin_s_i;
                        st_d.mode    = pin_s_i ? PM_GPIO : PM_HOLD;
                    end
                end
            end
            PM_HOLD: begin
                if (pin_s_i) st_d.mode = PM_GPIO;
            end
            PM_RSTPIN, PM_GPIO: begin
                // Settled modes: a non-power-on reset keeps the selection.
                if (any_int_rst) st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) st_q <= MODE_RST_VAL;
        else       st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign isp_lat_o = st_q.isp_lat;
endmodule

// File: rtl/rpin_out_map.sv
module rpin_out_map
    import rpin_pkg::*;
(
    input  pin_mode_e mode_i,
    input  logic      pin_s_i,
    input  logic      isp_lat_i,
    output pin_out_t  out_o
);
    always_comb begin
        out_o = OUT_RST_VAL;
        unique case (mode_i)
            PM_PWRUP, PM_RSTPIN: begin
                out_o.ext_rst = ~pin_s_i;
                out_o.gpio    = 1'b1;
                out_o.isp     = ~pin_s_i;
            end
            PM_HOLD: begin
                out_o.ext_rst = 1'b1;
                out_o.gpio    = 1'b1;
                out_o.isp     = isp_lat_i;
            end
            PM_GPIO: begin
                out_o.ext_rst = 1'b0;
                out_o.gpio    = pin_s_i;
                out_o.isp     = isp_lat_i;
            end
        endcase
    end
endmodule

// File: rtl/rpin_sel.sv
module rpin_sel
    import rpin_pkg::*;
#(
    parameter int   N_INT_RST   = 3,
    parameter int   SYNC_STAGES = 2,
    parameter logic PIN_IDLE    = 1'b1,
    parameter bit   OUT_REG     = 1'b0
) (
    input  logic                 clk_i,
    input  logic                 por_i,
    input  logic                 pwrup_done_i,
    input  logic                 fuse_rst_en_i,
    input  logic                 pin_raw_i,
    input  logic [N_INT_RST-1:0] int_rst_req_i,
    output logic                 ext_rst_req_o,
    output logic                 gpio_data_o,
    output logic                 isp_en_o
);
    logic      pin_s;
    pin_mode_e mode_w;
    logic      isp_lat_w;
    pin_out_t  out_comb;
    pin_out_t  out_fin;

    rpin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .din_i  (pin_raw_i),
        .dout_o (pin_s)
    );

    rpin_mode_fsm #(.N_INT_RST(N_INT_RST)) i_fsm (
        .clk_i         (clk_i),
        .por_i         (por_i),
        .pwrup_done_i  (pwrup_done_i),
        .fuse_rst_en_i (fuse_rst_en_i),
        .pin_s_i       (pin_s),
        .int_rst_req_i (int_rst_req_i),
        .mode_o        (mode_w),
        .isp_lat_o     (isp_lat_w)
    );

    rpin_out_map i_map (
        .mode_i    (mode_w),
        .pin_s_i   (pin_s),
        .isp_lat_i (isp_lat_w),
        .out_o     (out_comb)
    );

    generate
        if (OUT_REG) begin : g_out_reg
            pin_out_t out_d, out_q;
            always_comb out_d = out_comb;
            always_ff @(posedge clk_i or posedge por_i) begin
                if (por_i) out_q <= OUT_RST_VAL;
                else       out_q <= out_d;
            end
            assign out_fin = out_q;
        end else begin : g_out_comb
            assign out_fin = out_comb;
        end
    endgenerate

    assign ext_rst_req_o = out_fin.ext_rst;
    assign gpio_data_o   = out_fin.gpio;
    assign isp_en_o      = out_fin.isp;
endmodule

// File: rtl/rpin_sel_chk.sv
module rpin_sel_chk
    import rpin_pkg::*;
#(
    parameter int N_INT_RST = 3,
    parameter bit OUT_REG   = 1'b0
) (
    input logic                 clk_i,
    input logic                 por_i,
    input logic                 pin_raw_i,
    input logic [N_INT_RST-1:0] int_rst_req_i,
    input pin_mode_e            mode_w,
    input logic                 pin_s,
    input logic                 ext_rst_req_o,
    input logic                 gpio_data_o,
    input logic                 isp_en_o
);
    assert_pwrup_gpio_high_R1: assert property (@(posedge clk_i) disable iff (por_i)
        (mode_w == PM_PWRUP) |-> gpio_data_o);

    assert_gpio_no_reset_R3: assert property (@(posedge clk_i) disable iff (por_i)
        (mode_w == PM_GPIO) |-> !ext_rst_req_o);

    assert_hold_until_high_R4: assert property (@(posedge clk_i) disable iff (por_i)
        (mode_w == PM_HOLD && !pin_s) |=> (mode_w == PM_HOLD));

    assert_isp_tracks_reset_R5: assert property (@(posedge clk_i) disable iff (por_i)
        (!OUT_REG && (mode_w == PM_RSTPIN)) |-> (isp_en_o == ext_rst_req_o));

    assert_isp_latched_R6: assert property (@(posedge clk_i) disable iff (por_i)
        (!OUT_REG && mode_w == PM_GPIO && $past(mode_w) == PM_GPIO) |-> $stable(isp_en_o));

    assert_rstpin_sticky_R7: assert property (@(posedge clk_i) disable iff (por_i)
        (mode_w == PM_RSTPIN) |=> (mode_w == PM_RSTPIN));

    assert_gpio_sticky_R8: assert property (@(posedge clk_i) disable iff (por_i)
        (mode_w == PM_GPIO && (|int_rst_req_i)) |=> (mode_w == PM_GPIO));

    assert_two_stage_sync_R9: assert property (@(posedge clk_i) disable iff (por_i)
        (!OUT_REG && mode_w == PM_GPIO && $past(mode_w, 2) == PM_GPIO)
            |-> (gpio_data_o == $past(pin_raw_i, 2)));
endmodule

bind rpin_sel rpin_sel_chk #(.N_INT_RST(N_INT_RST), .OUT_REG(OUT_REG)) i_rpin_sel_chk (
    .clk_i         (clk_i),
    .por_i         (por_i),
    .pin_raw_i     (pin_raw_i),
    .int_rst_req_i (int_rst_req_i),
    .mode_w        (mode_w),
    .pin_s         (pin_s),
    .ext_rst_req_o (ext_rst_req_o),
    .gpio_data_o   (gpio_data_o),
    .isp_en_o      (isp_en_o)
);

// File: tb/test_rpin_sel.sv
module test_rpin_sel;
    localparam int NI = 3;

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic          strobe = 1'b0;
    logic          fuse = 1'b0;
    logic          pin = 1'b1;
    logic [NI-1:0] irq = '0;
    logic          ext_rst, gpio, isp;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rpin_sel #(.N_INT_RST(NI)) i_rpin_sel (
        .clk_i         (clk),
        .por_i         (por),
        .pwrup_done_i  (strobe),
        .fuse_rst_en_i (fuse),
        .pin_raw_i     (pin),
        .int_rst_req_i (irq),
        .ext_rst_req_o (ext_rst),
        .gpio_data_o   (gpio),
        .isp_en_o      (isp)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic power_on(logic f, logic p);
        @(negedge clk);
        por = 1'b1; fuse = f; pin = p; strobe = 1'b0; irq = '0;
        edges(2);
        por = 1'b0;
        edges(3);
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1;
        edges(1);
        strobe = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        por = 1'b1; pin = 1'b0;
        edges(2);
        chk("R10", "ext_rst under por", ext_rst, 1'b0);
        chk("R10", "gpio under por", gpio, 1'b1);
        chk("R10", "isp under por", isp, 1'b0);
    endtask

    task automatic t_pwrup_override();
        power_on(1'b0, 1'b0);
        chk("R1", "ext_rst low pin before strobe", ext_rst, 1'b1);
        chk("R1", "isp low pin before strobe", isp, 1'b1);
        chk("R1", "gpio before strobe", gpio, 1'b1);
        pin = 1'b1; edges(3);
        chk("R1", "ext_rst high pin before strobe", ext_rst, 1'b0);
        chk("R1", "isp high pin before strobe", isp, 1'b0);
    endtask

    task automatic t_reset_mode();
        power_on(1'b1, 1'b1);
        pulse_strobe(); edges(1);
        chk("R2", "ext_rst idle", ext_rst, 1'b0);
        chk("R2", "gpio in reset mode", gpio, 1'b1);
        pin = 1'b0; edges(3);
        chk("R2", "ext_rst pin low", ext_rst, 1'b1);
        chk("R5", "isp pin low", isp, 1'b1);
        pin = 1'b1; edges(3);
        chk("R5", "isp pin high", isp, 1'b0);
        fuse = 1'b0; pulse_strobe(); edges(1);
        pin = 1'b0; edges(3);
        chk("R7", "reset kept after fuse flip", ext_rst, 1'b1);
        chk("R7", "gpio still 1", gpio, 1'b1);
        pin = 1'b1; irq = 3'b101; edges(2); irq = '0; edges(1);
        pin = 1'b0; edges(3);
        chk("R8", "reset kept after internal reset", ext_rst, 1'b1);
    endtask

    task automatic t_gpio_mode();
        power_on(1'b0, 1'b1);
        pulse_strobe(); edges(1);
        chk("R3", "ext_rst in gpio", ext_rst, 1'b0);
        chk("R3", "gpio high", gpio, 1'b1);
        chk("R6", "isp latched off", isp, 1'b0);
        pin = 1'b0;
        edges(1);
        chk("R9", "gpio after one edge", gpio, 1'b1);
        edges(1);
        chk("R9", "gpio after two edges", gpio, 1'b0);
        chk("R3", "no reset with pin low", ext_rst, 1'b0);
        chk("R6", "isp ignores later low pin", isp, 1'b0);
        fuse = 1'b1; pulse_strobe(); edges(2);
        chk("R7", "gpio kept after fuse flip", ext_rst, 1'b0);
        irq = 3'b010; edges(2); irq = '0;
        pin = 1'b1; edges(3);
        chk("R8", "gpio follows after internal reset", gpio, 1'b1);
        chk("R8", "no reset after internal reset", ext_rst, 1'b0);
    endtask

    task automatic t_gpio_hold();
        power_on(1'b0, 1'b0);
        pulse_strobe(); edges(1);
        chk("R4", "held in reset", ext_rst, 1'b1);
        chk("R6", "isp latched on", isp, 1'b1);
        edges(5);
        chk("R4", "still held", ext_rst, 1'b1);
        pin = 1'b1; edges(4);
        chk("R4", "released after pin high", ext_rst, 1'b0);
        chk("R4", "gpio after release", gpio, 1'b1);
        pin = 1'b0; edges(3);
        chk("R4", "gpio low pin", gpio, 1'b0);
        chk("R6", "isp held on", isp, 1'b1);
        chk("R4", "no reset after release", ext_rst, 1'b0);
        power_on(1'b0, 1'b1);
        pulse_strobe(); edges(1);
        chk("R10", "latch cleared by por", isp, 1'b0);
    endtask

    initial begin
        edges(1);
        t_reset_state();
        t_pwrup_override();
        t_reset_mode();
        t_gpio_mode();
        t_gpio_hold();
        edges(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule